// File: doc/BRIEF.md
# Time-Multiplexed Waveform Table Sequencer

This block is the transmit side of a two-tone FSK modulator whose waveform lives in an external lookup table. Every master-clock cycle it steps through a repeating four-phase cycle. In the first two phases it sends a 12-bit table address, 6 bits at a time, on a narrow output bus. In the last two phases it collects the 8-bit sample the table returns, 4 bits at a time, on a narrow input bus. The completed sample is then handed to an 8-bit DAC holding register in a single update.

The table address combines three things: the position of the sample within the current bit, the bit being sent now, and the nine bits sent before it. This lets the table shape each transition according to recent history. The master clock runs at 64 times the bit rate. A full lookup takes one transmit-clock period (4 master cycles), a new sample index starts every 16 master cycles, and each bit therefore spans 4 samples.

A one-cycle strobe marks the last cycle of each bit period. On that edge the block takes the next transmit bit from its serial input.

Top module: `wave_lut_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the master-cycle counter to zero, clears the current bit and all nine history bits, and loads the DAC register with 0x80. While reset is held, the outputs show phase 0, address bus 0, no strobe and DAC value 0x80.
- R2: `lutPhase` equals the number of master cycles since reset, modulo 4. Phase 3 is always followed by phase 0.
- R3: In phase 0 the address bus carries table address bits [5:0]. In phase 1 it carries bits [11:6]. In phases 2 and 3 it is driven to zero.
- R4: The table address is built as follows: bits [1:0] hold the sample index, bit 2 holds the current bit, and bits [11:3] hold the previous bits, with bit 3 the most recent and bit 11 the oldest.
- R5: The sample index equals (cycles since reset / 16) modulo 4. The address stays unchanged across each 16-cycle window.
- R6: At the clock edge that ends phase 2, `lutData` is captured as the low nibble of the sample. At the edge that ends phase 3, it is captured as the high nibble.
- R7: `dacValue` changes only at the edge that ends phase 3, and it then takes all 8 bits of the new sample at once. A new low nibble paired with an old high nibble is never visible.
- R8: `bitStrobe` is high for exactly one cycle in every 64: the cycle whose count since reset is 63 modulo 64.
- R9: At the edge where `bitStrobe` is high, `txBitIn` becomes the current bit and the old current bit moves into history bit 0 (address bit 3). In all other cycles `txBitIn` has no effect on the address.
- R10: The value on `lutData` during phases 0 and 1 has no effect on `dacValue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 64 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| txBitIn | input | 1 | Next encoded transmit bit, sampled on the strobe edge |
| lutData | input | 4 | Nibble returned by the external table |
| lutAddr | output | 6 | Multiplexed table address half |
| lutPhase | output | 2 | Current phase of the four-phase access cycle |
| bitStrobe | output | 1 | High in the last cycle of each bit period |
| dacValue | output | 8 | Sample held for the DAC |

## Verification
The main hazard is a torn DAC update. If the DAC register loads the low nibble at the end of phase 2, it shows a new low nibble beside the old high nibble for one cycle; the bench compares `dacValue` in every cycle, so that skew appears as a mismatch. The bench drives random values on `lutData` during the address phases, which catches capture logic sampling in the wrong phase. It also drives the complement of the next bit on `txBitIn` in every cycle except the strobe cycle, so a history register that shifts on the wrong cycle or an address with misplaced bits produces wrong addresses. Long runs of identical bits fill the history, and a reset in mid-bit checks that the counter and the DAC return to their start values.

// File: rtl/lutseq_pkg.sv
package lutseq_pkg;

  // Samples per bit is 2**SAMPLE_W
  localparam int SAMPLE_W = 2;

  typedef enum logic [1:0] {
    PH_ADDR_LO = 2'd0,
    PH_ADDR_HI = 2'd1,
    PH_DATA_LO = 2'd2,
    PH_DATA_HI = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    phase_e              phase;
    logic [SAMPLE_W-1:0] sampleIdx;
    logic                capLow;
    logic                loadDac;
    logic                shiftBit;
  } seqCtl_t;

endpackage

// File: rtl/lutseq_ctrl.sv
module lutseq_ctrl
  import lutseq_pkg::*;
#(
  parameter int SLOT_W = 2  // tx clocks per sample is 2**SLOT_W
) (
  input  logic    clk,
  input  logic    rst,
  output seqCtl_t ctl,
  output logic    bitStrobe
);

  localparam int CNT_W = 2 + SLOT_W + SAMPLE_W;

  logic [CNT_W-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (rst) cycCnt <= '0;
    else     cycCnt <= cycCnt + 1'b1;
  end

  assign ctl.phase     = phase_e'(cycCnt[1:0]);
  assign ctl.sampleIdx = cycCnt[CNT_W-1 -: SAMPLE_W];
  assign ctl.capLow    = (cycCnt[1:0] == 2'd2);
  assign ctl.loadDac   = (cycCnt[1:0] == 2'd3);
  assign ctl.shiftBit  = &cycCnt;
  assign bitStrobe     = ctl.shiftBit;

  // R2: the phase sequence wraps from the last data phase back to address low
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl.phase == PH_DATA_HI) |=> (ctl.phase == PH_ADDR_LO));

  // R8: the bit strobe never lasts two cycles
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    bitStrobe |=> !bitStrobe);

  // R5: a new bit always starts at sample 0, phase 0
  p_strobe_realign_r5: assert property (@(posedge clk) disable iff (rst)
    bitStrobe |=> (ctl.sampleIdx == '0 && ctl.phase == PH_ADDR_LO));

endmodule

// File: rtl/lutseq_datapath.sv
module lutseq_datapath
  import lutseq_pkg::*;
#(
  parameter int          HIST_W  = 9,
  parameter int          OUT_W   = 6,
  parameter int          IN_W    = 4,
  parameter int          DAC_W   = 2 * IN_W,
  parameter logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  seqCtl_t          ctl,
  input  logic             txBitIn,
  input  logic [IN_W-1:0]  lutData,
  output logic [OUT_W-1:0] lutAddr,
  output logic [DAC_W-1:0] dacValue
);

  localparam int ADDR_W = HIST_W + 1 + SAMPLE_W;

  logic              curBit;
  logic [HIST_W-1:0] bitHist;
  logic [ADDR_W-1:0] fullAddr;
  logic [IN_W-1:0]   lowNib;
  logic [DAC_W-1:0]  dacReg;

  // Bit history: current bit moves into the newest history slot on the strobe
  always_ff @(posedge clk) begin
    if (rst) curBit <= 1'b0;
    else if (ctl.shiftBit) curBit <= txBitIn;
  end

  generate
    if (HIST_W > 1) begin : g_histShift
      always_ff @(posedge clk) begin
        if (rst) bitHist <= '0;
        else if (ctl.shiftBit) bitHist <= {bitHist[HIST_W-2:0], curBit};
      end
    end else begin : g_histSingle
      always_ff @(posedge clk) begin
        if (rst) bitHist <= '0;
        else if (ctl.shiftBit) bitHist <= curBit;
      end
    end
  endgenerate

  assign fullAddr = {bitHist, curBit, ctl.sampleIdx};

  // Address half multiplexer
  always_comb begin
    unique case (ctl.phase)
      PH_ADDR_LO: lutAddr = fullAddr[OUT_W-1:0];
      PH_ADDR_HI: lutAddr = OUT_W'(fullAddr[ADDR_W-1:OUT_W]);
      default:    lutAddr = '0;
    endcase
  end

  // Double-buffered sample capture
  always_ff @(posedge clk) begin
    if (rst) lowNib <= '0;
    else if (ctl.capLow) lowNib <= lutData;
  end

  always_ff @(posedge clk) begin
    if (rst) dacReg <= DAC_MID;
    else if (ctl.loadDac) dacReg <= {lutData, lowNib};
  end

  assign dacValue = dacReg;

  // R7: DAC holds outside the final data phase
  p_dac_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadDac |=> $stable(dacValue));

  // R9: the old current bit lands in the newest history slot
  p_hist_shift_r9: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftBit |=> (bitHist[0] == $past(curBit)));

  // R9: without the strobe the bit state does not move
  p_hist_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl.shiftBit |=> ($stable(bitHist) && $stable(curBit)));

endmodule

// File: rtl/wave_lut_sequencer.sv
module wave_lut_sequencer
  import lutseq_pkg::*;
#(
  parameter int HIST_W = 9,
  parameter int SLOT_W = 2,
  parameter int OUT_W  = 6,
  parameter int IN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txBitIn,
  input  logic [IN_W-1:0]   lutData,
  output logic [OUT_W-1:0]  lutAddr,
  output logic [1:0]        lutPhase,
  output logic              bitStrobe,
  output logic [2*IN_W-1:0] dacValue
);

  seqCtl_t ctl;

  lutseq_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .bitStrobe (bitStrobe)
  );

  lutseq_datapath #(
    .HIST_W (HIST_W),
    .OUT_W  (OUT_W),
    .IN_W   (IN_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .txBitIn  (txBitIn),
    .lutData  (lutData),
    .lutAddr  (lutAddr),
    .dacValue (dacValue)
  );

  assign lutPhase = ctl.phase;

endmodule

// File: tb/tb_wave_lut_sequencer.sv
`timescale 1ns/1ps
module tb_wave_lut_sequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txBitIn = 1'b0;
  logic [3:0] lutData = 4'h0;
  logic [5:0] lutAddr;
  logic [1:0] lutPhase;
  logic       bitStrobe;
  logic [7:0] dacValue;

  int nChk = 0;
  int nBad = 0;

  // Reference model state
  int         mCnt = 0;
  logic       mCur = 1'b0;
  logic [8:0] mHist = '0;
  logic [7:0] mDac = 8'h80;
  logic [3:0] mLow = 4'h0;

  always #2.5 clk = ~clk;

  wave_lut_sequencer dut (
    .clk(clk), .rst(rst), .txBitIn(txBitIn), .lutData(lutData),
    .lutAddr(lutAddr), .lutPhase(lutPhase), .bitStrobe(bitStrobe),
    .dacValue(dacValue)
  );

  function automatic logic [7:0] tbl(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  task automatic ck(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mCnt = 0; mCur = 1'b0; mHist = '0; mDac = 8'h80; mLow = 4'h0;
  endtask

  // One master cycle: check outputs at negedge, drive, advance model
  task automatic step(input logic bitVal, input bit junk);
    logic [11:0] full;
    logic [5:0]  expA;
    logic [1:0]  ph;
    logic [3:0]  drv;
    ph   = 2'(mCnt % 4);
    full = {mHist, mCur, 2'((mCnt / 16) % 4)};
    expA = (ph == 2'd0) ? full[5:0] : (ph == 2'd1) ? full[11:6] : 6'd0;
    ck(lutPhase == ph, "R2 phase", lutPhase, ph);
    ck(lutAddr == expA, "R3/R4/R5 address", lutAddr, expA);
    ck(bitStrobe == (mCnt % 64 == 63), "R8 strobe", bitStrobe, (mCnt % 64 == 63));
    ck(dacValue == mDac, "R6/R7/R10 dac", dacValue, mDac);
    if (ph == 2'd2)      drv = tbl(full)[3:0];
    else if (ph == 2'd3) drv = tbl(full)[7:4];
    else                 drv = junk ? 4'($urandom) : 4'h0;
    lutData = drv;
    txBitIn = (mCnt % 64 == 63) ? bitVal : ~bitVal;  // R9: off-strobe value is ignored
    if (ph == 2'd2) mLow = drv;
    if (ph == 2'd3) mDac = {drv, mLow};
    if (mCnt % 64 == 63) begin
      mHist = {mHist[7:0], mCur};
      mCur  = bitVal;
    end
    mCnt++;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input bit junk);
    for (int i = 0; i < 64; i++) step(b, junk);
  endtask

  task automatic doReset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      modelReset();
      ck(dacValue == 8'h80, "R1 dac mid", dacValue, 8'h80);
      ck(lutAddr == 6'd0, "R1 addr", lutAddr, 0);
      ck(lutPhase == 2'd0, "R1 phase", lutPhase, 0);
      ck(bitStrobe == 1'b0, "R1 strobe", bitStrobe, 0);
    end
    rst = 1'b0;
  endtask

  task automatic test_reset();
    doReset(3);
  endtask

  task automatic test_pattern();
    logic [10:0] pat = 11'b10110010111;
    for (int i = 0; i < 11; i++) sendBit(pat[i], 1'b0);
  endtask

  task automatic test_junk_r10();
    logic [7:0] pat = 8'b01101001;
    for (int i = 0; i < 8; i++) sendBit(pat[i], 1'b1);
  endtask

  task automatic test_history_fill_r4();
    for (int i = 0; i < 12; i++) sendBit(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) sendBit(1'b0, 1'b1);
  endtask

  task automatic test_midrun_reset_r1();
    sendBit(1'b1, 1'b0);
    for (int i = 0; i < 27; i++) step(1'b0, 1'b1);
    doReset(1);
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_pattern();
    test_junk_r10();
    test_history_fill_r4();
    test_midrun_reset_r1();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule